// File: doc/BRIEF.md
# Wake and Kickstart Interrupt Logic

This block keeps two sticky event flags for a battery-backed timekeeping device: one for a wake-up alarm and one for a kickstart button. Each flag has its own enable bit. An enabled, pending flag pulls on two active-low outputs: a system power-on request and a host interrupt. Which of the two is pulled depends on whether main supply is present. With supply absent, only the power-on request is driven, to wake the system. The interrupt that was held back is raised once supply returns, if the flag is still pending and enabled.

The alarm comparator, the timekeeping counters and the supply detector sit elsewhere. They arrive here as a single-cycle alarm pulse and a supply-present level, both synchronous to `clk`. The kickstart button arrives as a raw active-low pin. It is synchronized inside the block, and only its falling edges count. Software reaches the flags and the control bits through a simple write port and a combinational read port. The power-on request is brought out as an output-enable and a level, so the board can build a tri-state driver from them. A control bit chooses whether that request floats or stays driven while supply is absent and nothing is pending.

Reset is asynchronous and active low. Its release is expected to be synchronous to `clk`.

Top module: `wk_wake_irq`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it: both flags and all control bits are 0, `irq_n`=1, `pwr_oe`=0 and `pwr_lvl`=1.
- R2: The wake flag is status bit 1. A one-cycle `alarm_hit` sets it at that clock edge. A write to the status register (address 0) loads it from `wr_data[1]`, so writing 1 sets it and writing 0 clears it.
- R3: The kickstart flag is status bit 0. A write loads it from `wr_data[0]`. A high-to-low change of `kick_n` sampled at edge e sets it at edge e+2. A pin held low does not set the flag again after it has been cleared.
- R4: If a hardware event and a status write of 0 to the same flag occur in the same cycle, the flag ends up set.
- R5: With `supply_ok`=1, a pending flag whose enable is 1 drives `irq_n`=0, `pwr_oe`=1 and `pwr_lvl`=0 from the edge after the flag is set. The control register is address 1. Bit 0 enables kickstart, bit 1 enables wake, and bit 2 is the keep-driven select.
- R6: With `supply_ok`=0, `irq_n` is 1 from the following edge. An enabled, pending flag still drives `pwr_oe`=1 and `pwr_lvl`=0.
- R7: When `supply_ok` returns to 1 while an enabled flag is pending, `irq_n` goes to 0 on the next edge.
- R8: A flag whose enable bit is 0 leaves `irq_n`, `pwr_oe` and `pwr_lvl` at their idle values. The flag itself is still set and can be read.
- R9: With `supply_ok`=0 and nothing enabled pending, `pwr_oe` is 0 when the keep-driven bit is 0. When the bit is 1, `pwr_oe` is 1 with `pwr_lvl`=1.
- R10: `rd_data` shows the status register at address 0 and the control register at address 1, in the bit positions given above, with unused bits 0. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_hit | input | 1 | One-cycle wake alarm match pulse |
| kick_n | input | 1 | Raw active-low kickstart pin |
| supply_ok | input | 1 | Main supply present level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| irq_n | output | 1 | Active-low host interrupt |
| pwr_oe | output | 1 | Power-on request output enable |
| pwr_lvl | output | 1 | Power-on request level when enabled (low = request) |

## Verification
Each event source is first tried alone with supply present. This separates the alarm path from the synchronized kickstart path, and the two-edge offset of the kickstart pin from the one-edge offset of the alarm. The same events are then repeated with the enables off, to show that flag storage is independent of output gating. Supply is then toggled around a pending event. Taking supply away shows whether the interrupt is withheld while the power request stays asserted. Restoring supply shows the deferred interrupt, and switching the keep-driven bit with nothing pending tells the floating and driven-high idle cases apart. Finally, writes of 0 are placed in the same cycle as hardware events to confirm which one wins, and a held-low pin after a clear shows that only edges count.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int NUM_EVT  = 2;
  localparam int EVT_KICK = 0;
  localparam int EVT_WAKE = 1;
  localparam int KEEP_BIT = NUM_EVT;

  typedef struct packed {
    logic               keep_pwr;
    logic [NUM_EVT-1:0] en;
  } wk_ctrl_t;
endpackage

// File: rtl/wk_kick_sync.sv
module wk_kick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  localparam int SH_W = STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[SH_W-2:0], pin_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_nxt;
  end

  assign fall = sh_q[SH_W-1] & ~sh_q[SH_W-2];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R3
endmodule

// File: rtl/wk_flag_cell.sv
module wk_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic wr_en,
  input  logic wr_val,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (wr_en) q_nxt = wr_val;
    if (hw_set) q_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> q); // R4
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_val && !hw_set) |=> !q); // R2
endmodule

// File: rtl/wk_out_ctrl.sv
module wk_out_ctrl #(
  parameter int NUM_EVT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] flags,
  input  logic [NUM_EVT-1:0] en,
  input  logic               keep_pwr,
  input  logic               supply_ok,
  output logic               irq_n,
  output logic               pwr_oe,
  output logic               pwr_lvl
);
  logic pending;
  logic irq_n_nxt, oe_nxt, lvl_nxt;

  always_comb begin
    pending   = |(flags & en);
    irq_n_nxt = ~(supply_ok & pending);
    oe_nxt    = supply_ok | keep_pwr | pending;
    lvl_nxt   = ~pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n   <= 1'b1;
      pwr_oe  <= 1'b0;
      pwr_lvl <= 1'b1;
    end else begin
      irq_n   <= irq_n_nxt;
      pwr_oe  <= oe_nxt;
      pwr_lvl <= lvl_nxt;
    end
  end

  AST_NO_IRQ_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> irq_n); // R6
  AST_PEND_REQUESTS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> (pwr_oe && !pwr_lvl)); // R5
  AST_IDLE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok && !keep_pwr && !pending) |=> !pwr_oe); // R9
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> (irq_n && pwr_lvl)); // R8
endmodule

// File: rtl/wk_wake_irq.sv
module wk_wake_irq
  import wk_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int SYNC_STG  = 2,
  parameter int STAT_ADDR = 0,
  parameter int CTRL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alarm_hit,
  input  logic              kick_n,
  input  logic              supply_ok,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_n,
  output logic              pwr_oe,
  output logic              pwr_lvl
);
  localparam int CTRL_W = NUM_EVT + 1;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic               kick_fall;
  logic [NUM_EVT-1:0] hw_evt;
  logic [NUM_EVT-1:0] flags;
  logic               stat_we;
  logic               ctrl_we;
  wk_ctrl_t           ctrl_q;
  wk_ctrl_t           ctrl_nxt;
  logic               unused_wr_bits;

  assign unused_wr_bits = ^wr_data[DATA_W-1:CTRL_W];

  wk_kick_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (kick_n),
    .fall  (kick_fall)
  );

  always_comb begin
    hw_evt           = '0;
    hw_evt[EVT_KICK] = kick_fall;
    hw_evt[EVT_WAKE] = alarm_hit;
    stat_we          = wr_en && (wr_addr == STAT_A);
    ctrl_we          = wr_en && (wr_addr == CTRL_A);
  end

  for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_flag
    wk_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (hw_evt[gi]),
      .wr_en  (stat_we),
      .wr_val (wr_data[gi]),
      .q      (flags[gi])
    );
  end

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (ctrl_we) ctrl_nxt = wk_ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_nxt;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == STAT_A)      rd_data[NUM_EVT-1:0] = flags;
    else if (rd_addr == CTRL_A) rd_data[CTRL_W-1:0]  = ctrl_q;
  end

  wk_out_ctrl #(.NUM_EVT(NUM_EVT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags     (flags),
    .en        (ctrl_q.en),
    .keep_pwr  (ctrl_q.keep_pwr),
    .supply_ok (supply_ok),
    .irq_n     (irq_n),
    .pwr_oe    (pwr_oe),
    .pwr_lvl   (pwr_lvl)
  );

  AST_RETURN_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && |(flags & ctrl_q.en)) |=> !irq_n); // R7
  AST_ALARM_SETS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> flags[EVT_WAKE]); // R2
  AST_PIN_EDGE_SETS_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    kick_fall |=> flags[EVT_KICK]); // R3
endmodule

// File: tb/sim_wk_wake_irq.sv
module sim_wk_wake_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alarm_hit = 1'b0;
  logic       kick_n = 1'b1;
  logic       supply_ok = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       irq_n, pwr_oe, pwr_lvl;

  int n_run = 0;
  int n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference state
  bit m_kf = 0, m_wf = 0, m_ke = 0, m_we = 0, m_keep = 0;
  bit m_irq_n = 1, m_oe = 0, m_lvl = 1;
  bit pin_hist[$] = '{1'b1, 1'b1, 1'b1};

  always #5 clk = ~clk;

  wk_wake_irq u0 (
    .clk(clk), .rst_n(rst_n), .alarm_hit(alarm_hit), .kick_n(kick_n),
    .supply_ok(supply_ok), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n), .pwr_oe(pwr_oe),
    .pwr_lvl(pwr_lvl)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_kf = 0; m_wf = 0; m_ke = 0; m_we = 0; m_keep = 0;
      m_irq_n = 1; m_oe = 0; m_lvl = 1;
      pin_hist = '{1'b1, 1'b1, 1'b1};
    end else begin
      bit pend, edge_seen, nkf, nwf;
      pend = (m_kf && m_ke) || (m_wf && m_we);
      m_irq_n = !(supply_ok && pend);
      m_oe = supply_ok || m_keep || pend;
      m_lvl = !pend;
      edge_seen = pin_hist[0] && !pin_hist[1];
      pin_hist.push_back(kick_n);
      void'(pin_hist.pop_front());
      nkf = m_kf; nwf = m_wf;
      if (wr_en && wr_addr == 2'd0) begin nkf = wr_data[0]; nwf = wr_data[1]; end
      if (edge_seen) nkf = 1;
      if (alarm_hit) nwf = 1;
      if (wr_en && wr_addr == 2'd1) begin
        m_ke = wr_data[0]; m_we = wr_data[1]; m_keep = wr_data[2];
      end
      m_kf = nkf; m_wf = nwf;
    end
  end

  function automatic bit [7:0] exp_rd();
    if (rd_addr == 2'd0) return {6'd0, m_wf, m_kf};
    if (rd_addr == 2'd1) return {5'd0, m_keep, m_we, m_ke};
    return 8'd0;
  endfunction

  task automatic chk(string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("irq_n", irq_n, m_irq_n);
      chk("pwr_oe", pwr_oe, m_oe);
      chk("pwr_lvl", pwr_lvl, m_lvl);
      chk("rd_data", rd_data, exp_rd());
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(negedge clk); #1;
      alarm_hit = 0; wr_en = 0;
    end
  endtask

  task automatic wreg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc();
  endtask

  task automatic pulse_alarm();
    @(negedge clk); #1;
    alarm_hit = 1;
    cyc();
  endtask

  // direct point checks on top of the per-cycle model compare
  task automatic expect_out(string tag, bit ei, bit eo, bit el);
    cur_req = tag;
    chk("irq_n pt", irq_n, ei);
    chk("pwr_oe pt", pwr_oe, eo);
    chk("pwr_lvl pt", pwr_lvl, el);
  endtask

  initial begin
    cur_req = "R1";
    cyc(3);
    @(negedge clk); #1 rst_n = 1;
    expect_out("R1", 1, 0, 1);
    rd_addr = 2'd1; cyc(); chk("ctrl after reset R1", rd_data, 0);
    rd_addr = 2'd0;

    // R5/R2: supply present, wake alarm
    cur_req = "R5"; supply_ok = 1;
    wreg(2'd1, 8'h03);
    pulse_alarm();
    cyc();
    expect_out("R5", 0, 1, 0);
    cur_req = "R2"; chk("wake flag R2", rd_data, 2);
    wreg(2'd0, 8'h00); cyc(2);
    chk("wake cleared R2", rd_data, 0);
    wreg(2'd0, 8'h02); cyc(2);
    chk("wake sw set R2", rd_data, 2);
    wreg(2'd0, 8'h00); cyc(2);

    // R3: kickstart edge, then held low
    cur_req = "R3";
    @(negedge clk); #1 kick_n = 0;
    cyc(4);
    chk("kick flag R3", rd_data, 1);
    wreg(2'd0, 8'h00); cyc(5);
    chk("held low no reset R3", rd_data, 0);
    kick_n = 1; cyc(4);

    // R4: event and clearing write in same cycle
    cur_req = "R4";
    @(negedge clk); #1 alarm_hit = 1; wr_en = 1; wr_addr = 2'd0; wr_data = 8'h00;
    cyc(); cyc();
    chk("wake kept R4", rd_data, 2);
    wreg(2'd0, 8'h00); cyc(2);

    // R8: enables off
    cur_req = "R8";
    wreg(2'd1, 8'h00);
    pulse_alarm();
    @(negedge clk); #1 kick_n = 0; cyc(5); kick_n = 1;
    cyc(3);
    expect_out("R8", 1, 1, 1);
    chk("flags still stored R8", rd_data, 3);
    wreg(2'd0, 8'h00); cyc(2);

    // R9: supply absent, nothing pending
    cur_req = "R9";
    supply_ok = 0; cyc(2);
    expect_out("R9", 1, 0, 1);
    wreg(2'd1, 8'h04); cyc(2);
    expect_out("R9", 1, 1, 1);
    wreg(2'd1, 8'h03); cyc(2);

    // R6: event while unpowered
    cur_req = "R6";
    @(negedge clk); #1 kick_n = 0; cyc(5); kick_n = 1;
    expect_out("R6", 1, 1, 0);
    cyc(4);

    // R7: supply returns
    cur_req = "R7";
    supply_ok = 1; cyc(2);
    expect_out("R7", 0, 1, 0);
    cur_req = "R6"; supply_ok = 0; cyc(2);
    expect_out("R6", 1, 1, 0);
    cur_req = "R7"; supply_ok = 1; cyc(2);
    wreg(2'd0, 8'h00); cyc(3);
    expect_out("R7", 1, 1, 1);

    // R10: read map
    cur_req = "R10";
    wreg(2'd1, 8'hFD); rd_addr = 2'd1; cyc();
    chk("ctrl readback R10", rd_data, 8'h05);
    rd_addr = 2'd2; cyc();
    chk("unmapped R10", rd_data, 0);
    rd_addr = 2'd3; cyc(2);

    // R1 again: asynchronous reset mid-run
    cur_req = "R1";
    wreg(2'd0, 8'h03);
    @(negedge clk); #1 rst_n = 0; cyc(2);
    expect_out("R1", 1, 0, 1);
    @(negedge clk); #1 rst_n = 1; cyc(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule